// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block moves 36-bit words from a write clock domain to an independent read clock domain. The two clocks may be unrelated or identical. Each side qualifies its transfers with an active-low select and an active-high enable. The block produces four flags, each registered on its own side's clock. The write side has a space-available flag and an active-low almost-full flag. The read side has a data-ready flag and an active-low almost-empty flag. The two threshold offsets are input buses. Each is captured on the first edge of its own clock after reset is released.

Read-side behaviour follows a timing mode taken from the mode input at reset. In standard mode the ready flag shows that memory is not empty, and the read bus changes only on an accepted read. In first-word-fall-through mode a one-word output register is filled automatically. The word is shown on the read bus with the ready flag high, and an accepted read consumes it. The pointers cross between domains as Gray codes through two-flop synchronisers, so every flag leaves its blocking state late and never early.

Top module: `dual_clk_flag_fifo`

## Requirements
- R1: While reset is low, wrReady is 1, rdReady is 0, rdAlmostEmptyN is 0, wrAlmostFullN is 1 and rdData is all zeros.
- R2: A write happens on a wrClk rising edge only when wrCsN is 0 and wrEn is 1. A read happens on an rdClk rising edge only when rdCsN is 0 and rdEn is 1. Any other combination leaves the stored data, the flags and rdData unchanged.
- R3: Words leave in the order they were accepted, with all 36 bits intact, across any number of pointer wrap-arounds.
- R4: wrReady is 1 while memory has a free location, and 0 once DEPTH words are stored and unread. A write attempted while wrReady is 0 is dropped.
- R5: On each wrClk edge, wrAlmostFullN becomes 0 when the free locations in memory are at or below the almost-full offset, and 1 otherwise.
- R6: On each rdClk edge, rdAlmostEmptyN becomes 0 when the words in memory (not counting the fall-through output register) are at or below the almost-empty offset, and 1 otherwise.
- R7: The mode and the almost-empty offset are captured on the first rdClk edge after reset is released. The almost-full offset is captured on the first wrClk edge after reset is released. Later changes on these inputs have no effect until the next reset. modeSel=1 selects standard mode and modeSel=0 selects fall-through mode.
- R8: In standard mode, rdReady is 1 when memory holds a word. rdData changes only after an accepted read, and then carries the next word from the edge of that read.
- R9: In fall-through mode, the oldest word appears on rdData with rdReady=1 and no read needed. It stays there until a read is accepted.
- R10: A read attempted while rdReady is 0 is dropped. It does not disturb rdData or later ordering.
- R11: The write and read Gray pointers change at most one bit per edge. A word written into an empty FIFO is not flagged ready on the read side within one read clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low master reset |
| modeSel | input | 1 | Timing mode, captured at reset: 1 standard, 0 fall-through |
| afOffset | input | PW | Almost-full threshold in free locations |
| aeOffset | input | PW | Almost-empty threshold in stored words |
| wrCsN | input | 1 | Write select, active low |
| wrEn | input | 1 | Write enable |
| wrData | input | DATA_W | Write word |
| wrReady | output | 1 | Space available (low means full) |
| wrAlmostFullN | output | 1 | Almost-full flag, active low |
| rdCsN | input | 1 | Read select, active low |
| rdEn | input | 1 | Read enable |
| rdData | output | DATA_W | Read word |
| rdReady | output | 1 | Standard: memory not empty. Fall-through: word valid on rdData |
| rdAlmostEmptyN | output | 1 | Almost-empty flag, active low |

## Verification
Some properties are checked on every edge. These are the one-bit-per-edge movement of both Gray pointers, the consistency between each full or empty flag and its almost flag, and the rule that rdData holds still without an accepted read (standard mode) or while an unconsumed word waits (fall-through mode). The bench scenarios cover what depends on sequence and content. These are end-to-end ordering across wraps, the exact write at which the almost-full threshold is crossed, the almost-empty level after synchronisation settles, writes and reads that are dropped, and the mode latched at reset despite later toggling.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  typedef enum logic {
    MODE_FALL = 1'b0,
    MODE_STD  = 1'b1
  } rdMode_e;

  typedef struct packed {
    logic push;
    logic pop;
  } memStrobe_t;

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= '0;
    else       stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[s] <= '0;
      else       stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/afifo_wr_ctrl.sv
module afifo_wr_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int PW    = 5
) (
  input  logic          wrClk,
  input  logic          rstN,
  input  logic          wrCsN,
  input  logic          wrEn,
  input  logic [PW-1:0] afOffIn,
  input  logic [PW-1:0] rdGraySync,
  output logic          push,
  output logic [AW-1:0] wrAddr,
  output logic [PW-1:0] wrGray,
  output logic          wrSpace,
  output logic          wrAfN
);

  logic [PW-1:0] wrBin, wrBinNext, wrGrayNext, rdBinSync;
  logic [PW-1:0] usedNext, freeNext, afOffReg, afOffEff;
  logic          locked, wrReq;

  assign wrReq      = !wrCsN && wrEn;
  assign push       = wrReq && wrSpace;
  assign wrBinNext  = wrBin + PW'(push);
  assign wrGrayNext = wrBinNext ^ (wrBinNext >> 1);
  assign wrAddr     = wrBin[AW-1:0];
  assign afOffEff   = locked ? afOffReg : afOffIn;

  always_comb begin
    rdBinSync[PW-1] = rdGraySync[PW-1];
    for (int i = PW - 2; i >= 0; i--) rdBinSync[i] = rdBinSync[i+1] ^ rdGraySync[i];
  end

  assign usedNext = wrBinNext - rdBinSync;
  assign freeNext = PW'(DEPTH) - usedNext;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      wrSpace  <= 1'b1;
      wrAfN    <= 1'b1;
      afOffReg <= '0;
      locked   <= 1'b0;
    end else begin
      wrBin   <= wrBinNext;
      wrGray  <= wrGrayNext;
      wrSpace <= (usedNext != PW'(DEPTH));
      wrAfN   <= !(freeNext <= afOffEff);
      if (!locked) begin
        afOffReg <= afOffIn;
        locked   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/afifo_rd_ctrl.sv
module afifo_rd_ctrl
  import afifo_pkg::*;
#(
  parameter int AW = 4,
  parameter int PW = 5
) (
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          rdCsN,
  input  logic          rdEn,
  input  logic          modeSel,
  input  logic [PW-1:0] aeOffIn,
  input  logic [PW-1:0] wrGraySync,
  output logic          pop,
  output logic [AW-1:0] rdAddr,
  output logic [PW-1:0] rdGray,
  output logic          rdReady,
  output logic          rdAeN,
  output logic          rdStdMode
);

  rdMode_e       modeReg, modeEff;
  logic          locked, rdReq, memHas, outValid;
  logic [PW-1:0] rdBin, rdBinNext, rdGrayNext, wrBinSync, countNext;
  logic [PW-1:0] aeOffReg, aeOffEff;

  assign rdReq    = !rdCsN && rdEn;
  assign modeEff  = locked ? modeReg : rdMode_e'(modeSel);
  assign aeOffEff = locked ? aeOffReg : aeOffIn;

  always_comb begin
    if (modeEff == MODE_STD) pop = rdReq && memHas;
    else                     pop = memHas && (!outValid || rdReq);
  end

  assign rdBinNext  = rdBin + PW'(pop);
  assign rdGrayNext = rdBinNext ^ (rdBinNext >> 1);
  assign rdAddr     = rdBin[AW-1:0];

  always_comb begin
    wrBinSync[PW-1] = wrGraySync[PW-1];
    for (int i = PW - 2; i >= 0; i--) wrBinSync[i] = wrBinSync[i+1] ^ wrGraySync[i];
  end

  assign countNext = wrBinSync - rdBinNext;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      memHas   <= 1'b0;
      outValid <= 1'b0;
      rdAeN    <= 1'b0;
      modeReg  <= MODE_STD;
      aeOffReg <= '0;
      locked   <= 1'b0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= rdGrayNext;
      memHas <= (countNext != '0);
      rdAeN  <= !(countNext <= aeOffEff);
      if (modeEff == MODE_FALL) outValid <= pop || (outValid && !rdReq);
      else                      outValid <= 1'b0;
      if (!locked) begin
        modeReg  <= rdMode_e'(modeSel);
        aeOffReg <= aeOffIn;
        locked   <= 1'b1;
      end
    end
  end

  assign rdStdMode = (modeReg == MODE_STD);
  assign rdReady   = rdStdMode ? memHas : outValid;

endmodule

// File: rtl/afifo_datapath.sv
module afifo_datapath
  import afifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 16,
  parameter int AW     = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  memStrobe_t        strb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (strb.pop) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/dual_clk_flag_fifo.sv
module dual_clk_flag_fifo
  import afifo_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH),
  localparam int PW         = AW + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic [PW-1:0]     afOffset,
  input  logic [PW-1:0]     aeOffset,
  input  logic              wrCsN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  output logic              wrAlmostFullN,
  input  logic              rdCsN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdReady,
  output logic              rdAlmostEmptyN
);

  memStrobe_t    strb;
  logic          push, pop, rdStdMode;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [PW-1:0] wrGray, rdGray, wrGraySync, rdGraySync;

  assign strb.push = push;
  assign strb.pop  = pop;

  afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_syncW2R (
    .clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySync)
  );

  afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_syncR2W (
    .clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGraySync)
  );

  afifo_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wrCtrl (
    .wrClk(wrClk), .rstN(rstN), .wrCsN(wrCsN), .wrEn(wrEn),
    .afOffIn(afOffset), .rdGraySync(rdGraySync), .push(push),
    .wrAddr(wrAddr), .wrGray(wrGray), .wrSpace(wrReady), .wrAfN(wrAlmostFullN)
  );

  afifo_rd_ctrl #(.AW(AW), .PW(PW)) u_rdCtrl (
    .rdClk(rdClk), .rstN(rstN), .rdCsN(rdCsN), .rdEn(rdEn), .modeSel(modeSel),
    .aeOffIn(aeOffset), .wrGraySync(wrGraySync), .pop(pop), .rdAddr(rdAddr),
    .rdGray(rdGray), .rdReady(rdReady), .rdAeN(rdAlmostEmptyN), .rdStdMode(rdStdMode)
  );

  afifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_data (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/afifo_checks.sv
module afifo_checks #(
  parameter int DATA_W = 36,
  parameter int PW     = 5
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrReady,
  input logic              wrAlmostFullN,
  input logic              rdReady,
  input logic              rdAlmostEmptyN,
  input logic              rdCsN,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic [PW-1:0]     wrGray,
  input logic [PW-1:0]     rdGray,
  input logic              rdStdMode
);

  logic rdReq;
  assign rdReq = !rdCsN && rdEn;

  // R4 / R5: a full memory always leaves zero free locations, so almost-full is active
  a_r4_full_is_almost_full: assert property (@(posedge wrClk) disable iff (!rstN)
    !wrReady |-> !wrAlmostFullN);

  // R6 / R8: an empty memory always satisfies the almost-empty threshold
  a_r6_empty_is_almost_empty: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdStdMode && !rdReady) |-> !rdAlmostEmptyN);

  // R8: standard mode changes rdData only on an accepted read
  a_r8_std_data_holds: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdStdMode && !(rdReq && rdReady)) |=> $stable(rdData));

  // R9: a fall-through word waits until consumed
  a_r9_fall_word_waits: assert property (@(posedge rdClk) disable iff (!rstN)
    (!rdStdMode && rdReady && !rdReq) |=> (rdReady && $stable(rdData)));

  // R11: Gray pointers move one bit at a time
  a_r11_wr_gray_step: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0(wrGray ^ $past(wrGray)));

  a_r11_rd_gray_step: assert property (@(posedge rdClk) disable iff (!rstN)
    $onehot0(rdGray ^ $past(rdGray)));

endmodule

bind dual_clk_flag_fifo afifo_checks #(.DATA_W(DATA_W), .PW(PW)) u_checks (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrReady(wrReady),
  .wrAlmostFullN(wrAlmostFullN), .rdReady(rdReady), .rdAlmostEmptyN(rdAlmostEmptyN),
  .rdCsN(rdCsN), .rdEn(rdEn), .rdData(rdData), .wrGray(wrGray), .rdGray(rdGray),
  .rdStdMode(rdStdMode)
);

// File: tb/dual_clk_flag_fifo_tb.sv
`timescale 1ns/1ps
module dual_clk_flag_fifo_tb;

  localparam int DATA_W = 36;
  localparam int DEPTH  = 16;
  localparam int PW     = 5;

  logic              wrClk = 0, rdClk = 0, rstN = 0, modeSel = 0;
  logic [PW-1:0]     afOffset = 5'd3, aeOffset = 5'd2;
  logic              wrCsN = 1, wrEn = 0, rdCsN = 1, rdEn = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic              wrReady, wrAlmostFullN, rdReady, rdAlmostEmptyN;
  logic [DATA_W-1:0] rdData;

  int checks = 0, errors = 0;
  bit fallMode = 0;
  logic [DATA_W-1:0] expQ[$];
  logic [DATA_W-1:0] lastRead = '0;

  always #4 wrClk = ~wrClk;
  always #5 rdClk = ~rdClk;

  dual_clk_flag_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .modeSel(modeSel),
    .afOffset(afOffset), .aeOffset(aeOffset), .wrCsN(wrCsN), .wrEn(wrEn),
    .wrData(wrData), .wrReady(wrReady), .wrAlmostFullN(wrAlmostFullN),
    .rdCsN(rdCsN), .rdEn(rdEn), .rdData(rdData), .rdReady(rdReady),
    .rdAlmostEmptyN(rdAlmostEmptyN)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mkWord(int n);
    return {4'(n * 5 + 3), 32'hC0DE_0000 + 32'(n)};
  endfunction

  task automatic doReset(logic mode);
    rstN = 0; modeSel = mode; wrCsN = 1; wrEn = 0; rdCsN = 1; rdEn = 0;
    expQ.delete();
    repeat (4) @(negedge rdClk);
    rstN = 1;
  endtask

  task automatic waitRd(int n);
    repeat (n) @(negedge rdClk);
  endtask

  // driver: expected words go into the queue when the write is accepted
  task automatic wrBurst(int n, int base, logic cs = 0, logic en = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrCsN = cs; wrEn = en; wrData = mkWord(base + i);
      if (!cs && en && wrReady) expQ.push_back(wrData);
    end
    @(negedge wrClk);
    wrEn = 0; wrCsN = 1;
  endtask

  // monitor: pops the queue and compares as words come out
  task automatic readN(int n, string req);
    int got = 0;
    int guard = 0;
    bit pend = 0;
    while (got < n && guard < 2000) begin
      guard++;
      @(negedge rdClk);
      if (pend) begin
        lastRead = expQ.pop_front();
        chk(req, 64'(rdData), 64'(lastRead));
        pend = 0; got++;
      end
      if (got < n) begin
        rdCsN = 0; rdEn = 1;
        if (rdReady) begin
          if (fallMode) begin
            lastRead = expQ.pop_front();
            chk(req, 64'(rdData), 64'(lastRead));
            got++;
          end else pend = 1;
        end
      end else begin
        rdEn = 0; rdCsN = 1;
      end
    end
    if (fallMode) begin
      @(negedge rdClk);
      rdEn = 0; rdCsN = 1;
    end
    if (got < n) chk({req, " read timeout"}, 64'(got), 64'(n));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // ---------- fall-through phase ----------
    fallMode = 1;
    rstN = 0; modeSel = 0;
    repeat (3) @(negedge rdClk);
    chk("R1 wrReady", 64'(wrReady), 64'd1);
    chk("R1 rdReady", 64'(rdReady), 64'd0);
    chk("R1 almostEmptyN", 64'(rdAlmostEmptyN), 64'd0);
    chk("R1 almostFullN", 64'(wrAlmostFullN), 64'd1);
    chk("R1 rdData", 64'(rdData), 64'd0);
    doReset(1'b0);

    // R2: deselected or disabled writes are dropped
    wrBurst(5, 100, 1'b1, 1'b1);
    wrBurst(5, 200, 1'b0, 1'b0);
    waitRd(10);
    chk("R2 no write stored", 64'(rdReady), 64'd0);

    // R9: first word falls through without a read
    wrBurst(1, 1);
    waitRd(10);
    chk("R9 ready without read", 64'(rdReady), 64'd1);
    chk("R9 word presented", 64'(rdData), 64'(mkWord(1)));
    @(negedge rdClk); rdCsN = 1; rdEn = 1;
    waitRd(4);
    rdEn = 0;
    chk("R2 deselected read kept word", 64'(rdData), 64'(mkWord(1)));
    chk("R2 deselected read kept ready", 64'(rdReady), 64'd1);
    readN(1, "R3 fall-through order");
    waitRd(6);
    chk("R9 consumed leaves not ready", 64'(rdReady), 64'd0);

    // R4: fill until the write side reports full
    wrBurst(24, 10);
    waitRd(10);
    chk("R4 full after fill", 64'(wrReady), 64'd0);
    readN(expQ.size(), "R3 fall-through fill order");
    waitRd(10);
    chk("R4 space after drain", 64'(wrReady), 64'd1);

    // ---------- standard phase ----------
    fallMode = 0;
    doReset(1'b1);
    waitRd(2);
    modeSel = 0; // R7: later change must be ignored
    afOffset = 5'd9; aeOffset = 5'd9;
    wrBurst(12, 300);
    chk("R5 four free not almost full", 64'(wrAlmostFullN), 64'd1);
    wrBurst(1, 312);
    chk("R5 three free almost full", 64'(wrAlmostFullN), 64'd0);
    wrBurst(3, 313);
    chk("R4 full at depth", 64'(wrReady), 64'd0);
    wrBurst(2, 900);
    chk("R4 dropped writes", 64'(expQ.size()), 64'(DEPTH));
    waitRd(10);
    chk("R6 full memory not almost empty", 64'(rdAlmostEmptyN), 64'd1);
    chk("R8 ready when not empty", 64'(rdReady), 64'd1);
    chk("R7 R8 no fall-through data", 64'(rdData), 64'd0);

    readN(13, "R3 standard order");
    waitRd(4);
    chk("R6 three stored", 64'(rdAlmostEmptyN), 64'd1);
    readN(1, "R3 standard order");
    chk("R6 two stored", 64'(rdAlmostEmptyN), 64'd0);
    readN(2, "R3 standard order");
    waitRd(4);
    chk("R8 empty not ready", 64'(rdReady), 64'd0);

    // R10: reads on empty are dropped
    @(negedge rdClk); rdCsN = 0; rdEn = 1;
    waitRd(5);
    rdEn = 0; rdCsN = 1;
    chk("R10 rdData unchanged", 64'(rdData), 64'(lastRead));
    chk("R10 still not ready", 64'(rdReady), 64'd0);

    // R11: flag lags the write by the synchroniser
    wrBurst(1, 400);
    @(negedge rdClk);
    chk("R11 ready not early", 64'(rdReady), 64'd0);
    waitRd(6);
    readN(1, "R10 order after dropped reads");

    // R3: pointer wrap-around
    for (int k = 0; k < 4; k++) begin
      wrBurst(10, 500 + k * 10);
      waitRd(6);
      readN(10, "R3 wrap order");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule